// File: doc/BRIEF.md
# Shared Mailbox Lock Controller

This block is a mailbox that two requesters share: a system host and an embedded microcontroller. One of them at a time holds an ownership lock. The lock holder loads a command word, a length in dwords and a queue of data dwords, then hands the mailbox to the other side by setting the execute bit. The receiver drains the data queue, writes a result code, and the owner releases the lock by clearing the execute bit. The microcontroller also has a forced-unlock input that frees the lock whoever holds it. It has a direct-access port into the buffer that works only while the microcontroller is the receiver.

The buffer is a register array. Every dword is stored with a 7-bit SECDED check code. Reads through the data queue correct single-bit faults and count them. An uncorrectable fault sets a sticky error flag and pulses an interrupt, so firmware can fail the command and sanitize the buffer. The sanitize operation is a zeroize sweep that the microcontroller may start while it owns the lock.

Top module: `mbx_lock_ctrl`

## Requirements
- R1: A lock read (`h_lock_rd` or `u_lock_rd`) sees busy=0 in the same cycle when the mailbox is idle, and the lock is granted at the next edge: state becomes LOCKED (1) and `owner_is_uc` names the winner (0 = host, 1 = microcontroller). When the lock is already held, busy=1 and nothing changes. The state codes are IDLE=0, LOCKED=1, UC_EXEC=2, HOST_EXEC=3.
- R2: When both sides read the lock in the same idle cycle, the host is granted the lock and the microcontroller sees busy=1.
- R3: In LOCKED, the owner writing the execute select (`sel`=3) with bit 0 set moves the state to UC_EXEC when the host owns the lock, or to HOST_EXEC when the microcontroller owns it. The select codes are CMD=0, DLEN=1, DATAIN=2, EXEC=3, STATUS=4.
- R4: The owner writing the execute select with bit 0 clear, in LOCKED or in either execute state, releases the lock and returns the state to IDLE.
- R5: `u_force_unlock` returns the state to IDLE from any state at the next edge. The microcontroller can then acquire the lock.
- R6: A direct access (`u_dir_en`) is acknowledged (`u_dir_ack`=1 one cycle later, with the corrected read data) only in UC_EXEC. In any other state the acknowledge stays 0 and a direct write leaves the buffer unchanged.
- R7: In an execute state, each pop by the receiver gives `rd_valid`=1 one cycle later. Pops return the DATAIN dwords in order while the read index is below the programmed length (and below DEPTH). Once the index reaches that bound, a pop returns 0.
- R8: A single flipped bit in a stored codeword is corrected on a pop, and `corr_cnt` increments one cycle after `rd_valid` without setting `ecc_err`.
- R9: A double-bit fault found on a pop sets `ecc_err` and pulses `ecc_irq` for one cycle, one cycle after `rd_valid`. The flag stays set until `ecc_err_clr` is pulsed.
- R10: A pop at or past the programmed length reads no codeword and raises no error, even when the entry at that index holds a double-bit fault.
- R11: `u_zero_req` is accepted only while the microcontroller owns the lock. `zero_busy` is then high for exactly DEPTH cycles, after which every entry reads as zero with no error. Otherwise the request is ignored.
- R12: Only the receiver, in an execute state, can write the status field (DATA_READY=1, CMD_FAILURE=2). Status returns to BUSY (0) when the lock is granted.
- R13: The write and read indices return to 0 when the lock is granted, so the first DATAIN dword of each command lands at entry 0 and is the first dword popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_lock_rd | input | 1 | Host reads the lock register (lock request) |
| h_lock_busy | output | 1 | Lock value returned to the host, combinational |
| h_wr | input | 1 | Host register write strobe |
| h_sel | input | 3 | Host register select |
| h_wdata | input | 32 | Host write data |
| h_pop | input | 1 | Host pops a data-out dword |
| u_lock_rd | input | 1 | Microcontroller lock request |
| u_lock_busy | output | 1 | Lock value returned to the microcontroller |
| u_wr | input | 1 | Microcontroller register write strobe |
| u_sel | input | 3 | Microcontroller register select |
| u_wdata | input | 32 | Microcontroller write data |
| u_pop | input | 1 | Microcontroller pops a data-out dword |
| u_force_unlock | input | 1 | Forced release of the lock |
| u_dir_en | input | 1 | Direct buffer access request |
| u_dir_we | input | 1 | Direct access is a write |
| u_dir_addr | input | log2(DEPTH) | Direct access entry index |
| u_dir_wdata | input | 32 | Direct write data |
| u_dir_ack | output | 1 | Direct access accepted |
| u_dir_rdata | output | 32 | Direct read data, corrected |
| u_zero_req | input | 1 | Start a zeroize sweep |
| zero_busy | output | 1 | Zeroize sweep in progress |
| ecc_flip | input | 39 | XOR mask applied to the codeword on every data write (fault injection) |
| ecc_err_clr | input | 1 | Clears the sticky error flag (write-1-to-clear) |
| ecc_err | output | 1 | Sticky uncorrectable-error flag |
| ecc_irq | output | 1 | One-cycle error interrupt |
| corr_cnt | output | CNTW | Saturating count of corrected reads |
| rd_valid | output | 1 | Pop result valid |
| rd_data | output | 32 | Pop result data |
| mbx_state | output | 2 | Current mailbox state |
| owner_is_uc | output | 1 | Lock owner (1 = microcontroller) |
| mbx_cmd | output | 32 | Stored command word |
| mbx_dlen | output | 32 | Stored length in dwords |
| mbx_status | output | 2 | Status field |

## Verification
The main data path is swept over every programmed length from 0 to DEPTH, once with each side as the owner. Each sweep pops one dword past the buffer size, so the in-range, past-length and past-capacity cases are all separated, and stale data from earlier commands is caught through per-command patterns. Fault patterns put a single flipped bit inside the length, a double fault just past the length, and a double fault inside it. Together these separate correction, silent skipping and flagging. Direct access is tried in LOCKED, UC_EXEC and HOST_EXEC, and the zeroize request under host and microcontroller ownership, to tell legal from ignored requests.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LOCKED    = 2'd1,
        ST_EXEC_UC   = 2'd2,
        ST_EXEC_HOST = 2'd3
    } mbx_state_e;

    localparam logic [2:0] SEL_CMD    = 3'd0;
    localparam logic [2:0] SEL_DLEN   = 3'd1;
    localparam logic [2:0] SEL_DATAIN = 3'd2;
    localparam logic [2:0] SEL_EXEC   = 3'd3;
    localparam logic [2:0] SEL_STATUS = 3'd4;

    localparam logic [1:0] STS_BUSY = 2'd0;

    localparam int CW_W = 39;

    typedef struct packed {
        logic [31:0] data;
        logic        single;
        logic        dbl;
    } ecc_res_t;

    // Hamming layout: bit 0 is overall parity, positions 1..38 hold
    // check bits at powers of two and data elsewhere.
    function automatic logic [CW_W-1:0] ecc_encode(input logic [31:0] din);
        logic [CW_W-1:0] cw;
        logic            b;
        int              j;
        cw = '0;
        j  = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = din[j];
                j++;
            end
        end
        for (int k = 0; k < 6; k++) begin
            b = 1'b0;
            for (int p = 1; p < CW_W; p++) begin
                if (((p >> k) & 1) == 1 && p != (1 << k)) b = b ^ cw[p];
            end
            cw[1 << k] = b;
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic ecc_res_t ecc_check(input logic [CW_W-1:0] cw);
        ecc_res_t        r;
        logic [5:0]      syn;
        logic [CW_W-1:0] fix;
        logic            ovr;
        int              j;
        syn = '0;
        for (int k = 0; k < 6; k++) begin
            for (int p = 1; p < CW_W; p++) begin
                if (((p >> k) & 1) == 1) syn[k] = syn[k] ^ cw[p];
            end
        end
        ovr      = ^cw;
        fix      = cw;
        r.single = 1'b0;
        r.dbl    = 1'b0;
        if (ovr) begin
            r.single = 1'b1;
            if (syn != 6'd0 && int'(syn) < CW_W) fix[syn] = ~fix[syn];
        end else if (syn != 6'd0) begin
            r.dbl = 1'b1;
        end
        r.data = '0;
        j      = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                r.data[j] = fix[p];
                j++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mbx_arb.sv
module mbx_arb
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        h_lock_rd,
    input  logic        u_lock_rd,
    input  logic        u_force,
    input  logic        h_wr,
    input  logic [2:0]  h_sel,
    input  logic [31:0] h_wdata,
    input  logic        u_wr,
    input  logic [2:0]  u_sel,
    input  logic [31:0] u_wdata,
    output logic        h_busy,
    output logic        u_busy,
    output mbx_state_e  state,
    output logic        owner_uc,
    output logic [31:0] cmd,
    output logic [31:0] dlen,
    output logic [1:0]  status,
    output logic        grant,
    output logic        exec_go,
    output logic        din_we,
    output logic [31:0] din_data
);

    typedef struct packed {
        mbx_state_e  state;
        logic        owner_uc;
        logic [31:0] cmd;
        logic [31:0] dlen;
        logic [1:0]  status;
    } arb_t;

    arb_t q, d;

    logic        own_wr, rcv_wr;
    logic [2:0]  own_sel, rcv_sel;
    logic [31:0] own_data, rcv_data;

    always_comb begin
        d        = q;
        grant    = 1'b0;
        exec_go  = 1'b0;
        din_we   = 1'b0;
        own_wr   = q.owner_uc ? u_wr    : h_wr;
        own_sel  = q.owner_uc ? u_sel   : h_sel;
        own_data = q.owner_uc ? u_wdata : h_wdata;
        rcv_wr   = q.owner_uc ? h_wr    : u_wr;
        rcv_sel  = q.owner_uc ? h_sel   : u_sel;
        rcv_data = q.owner_uc ? h_wdata : u_wdata;
        din_data = own_data;
        h_busy   = (q.state != ST_IDLE) || u_force;
        u_busy   = h_busy || h_lock_rd;
        if (u_force) begin
            d.state = ST_IDLE;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                    if (h_lock_rd || u_lock_rd) begin
                        d.state    = ST_LOCKED;
                        d.owner_uc = !h_lock_rd;
                        d.status   = STS_BUSY;
                        grant      = 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (own_wr) begin
                        case (own_sel)
                            SEL_CMD:    d.cmd  = own_data;
                            SEL_DLEN:   d.dlen = own_data;
                            SEL_DATAIN: din_we = 1'b1;
                            SEL_EXEC: begin
                                if (own_data[0]) begin
                                    d.state = q.owner_uc ? ST_EXEC_HOST : ST_EXEC_UC;
                                    exec_go = 1'b1;
                                end else begin
                                    d.state = ST_IDLE;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                default: begin
                    if (own_wr && own_sel == SEL_EXEC && !own_data[0]) d.state = ST_IDLE;
                    if (rcv_wr && rcv_sel == SEL_STATUS) d.status = rcv_data[1:0];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign state    = q.state;
    assign owner_uc = q.owner_uc;
    assign cmd      = q.cmd;
    assign dlen     = q.dlen;
    assign status   = q.status;

    p_force_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        u_force |=> (q.state == ST_IDLE));

    p_host_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && h_lock_rd && !u_force) |=> (q.state == ST_LOCKED && !q.owner_uc));

    p_exec_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_EXEC_UC || q.state == ST_EXEC_HOST) && $past(q.state) != q.state)
        |-> ($past(q.state) == ST_LOCKED));

endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     grant,
    input  logic                     exec_go,
    input  logic                     din_we,
    input  logic [31:0]              din_data,
    input  logic [CW_W-1:0]          flip,
    input  logic                     pop,
    input  logic [31:0]              dlen,
    input  logic                     dir_en,
    input  logic                     dir_we,
    input  logic [$clog2(DEPTH)-1:0] dir_addr,
    input  logic [31:0]              dir_wdata,
    input  logic                     dir_allow,
    input  logic                     zero_req,
    input  logic                     zero_allow,
    output logic                     rd_valid,
    output logic [31:0]              rd_data,
    output logic                     rd_single,
    output logic                     rd_double,
    output logic                     dir_ack,
    output logic [31:0]              dir_rdata,
    output logic                     zero_busy
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][CW_W-1:0] mem;
        logic [PW-1:0]              wptr;
        logic [PW-1:0]              rptr;
        logic                       rd_valid;
        logic [31:0]                rd_data;
        logic                       rd_single;
        logic                       rd_double;
        logic                       dir_ack;
        logic [31:0]                dir_rdata;
        logic                       zbusy;
        logic [AW-1:0]              zidx;
    } st_t;

    st_t q, d;

    logic            we;
    logic [AW-1:0]   waddr;
    logic [CW_W-1:0] wcw;
    logic            in_range;
    logic            dir_ok;
    ecc_res_t        pop_res;
    ecc_res_t        dir_res;

    always_comb begin
        d           = q;
        d.rd_valid  = 1'b0;
        d.rd_single = 1'b0;
        d.rd_double = 1'b0;
        d.dir_ack   = 1'b0;
        we          = 1'b0;
        waddr       = '0;
        wcw         = '0;
        dir_ok      = dir_en && dir_allow && !q.zbusy;
        in_range    = ({{(32-PW){1'b0}}, q.rptr} < dlen) && (q.rptr < PW'(DEPTH));
        pop_res     = ecc_check(q.mem[q.rptr[AW-1:0]]);
        dir_res     = ecc_check(q.mem[dir_addr]);

        if (q.zbusy) begin
            we     = 1'b1;
            waddr  = q.zidx;
            wcw    = '0;
            d.zidx = q.zidx + 1'b1;
            if (q.zidx == AW'(DEPTH - 1)) d.zbusy = 1'b0;
        end else if (zero_req && zero_allow) begin
            d.zbusy = 1'b1;
            d.zidx  = '0;
        end else if (din_we) begin
            if (q.wptr < PW'(DEPTH)) begin
                we     = 1'b1;
                waddr  = q.wptr[AW-1:0];
                wcw    = ecc_encode(din_data) ^ flip;
                d.wptr = q.wptr + 1'b1;
            end
        end else if (dir_ok && dir_we) begin
            we    = 1'b1;
            waddr = dir_addr;
            wcw   = ecc_encode(dir_wdata) ^ flip;
        end

        if (dir_ok) begin
            d.dir_ack = 1'b1;
            if (!dir_we) d.dir_rdata = dir_res.data;
        end

        if (pop) begin
            d.rd_valid = 1'b1;
            if (in_range) begin
                d.rd_data   = pop_res.data;
                d.rd_single = pop_res.single;
                d.rd_double = pop_res.dbl;
                d.rptr      = q.rptr + 1'b1;
            end else begin
                d.rd_data = '0;
            end
        end

        if (exec_go) d.rptr = '0;
        if (grant) begin
            d.wptr = '0;
            d.rptr = '0;
        end

        if (we) d.mem[waddr] = wcw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_valid  = q.rd_valid;
    assign rd_data   = q.rd_data;
    assign rd_single = q.rd_single;
    assign rd_double = q.rd_double;
    assign dir_ack   = q.dir_ack;
    assign dir_rdata = q.dir_rdata;
    assign zero_busy = q.zbusy;

    p_zero_span_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.zbusy) |-> ($past(q.zidx) == AW'(DEPTH - 1)));

    p_beyond_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !in_range) |=> (q.rd_valid && !q.rd_double && q.rd_data == 32'd0));

endmodule

// File: rtl/mbx_err_track.sv
module mbx_err_track #(
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_valid,
    input  logic            rd_single,
    input  logic            rd_double,
    input  logic            clr,
    output logic            err,
    output logic            irq,
    output logic [CNTW-1:0] corr_cnt
);

    typedef struct packed {
        logic            err;
        logic            irq;
        logic [CNTW-1:0] cnt;
    } et_t;

    et_t q, d;

    always_comb begin
        d     = q;
        d.irq = rd_valid && rd_double;
        if (clr) d.err = 1'b0;
        if (rd_valid && rd_double) d.err = 1'b1;
        if (rd_valid && rd_single && q.cnt != {CNTW{1'b1}}) d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign err      = q.err;
    assign irq      = q.irq;
    assign corr_cnt = q.cnt;

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> q.err);

endmodule

// File: rtl/mbx_lock_ctrl.sv
module mbx_lock_ctrl
    import mbx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNTW  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     h_lock_rd,
    output logic                     h_lock_busy,
    input  logic                     h_wr,
    input  logic [2:0]               h_sel,
    input  logic [31:0]              h_wdata,
    input  logic                     h_pop,
    input  logic                     u_lock_rd,
    output logic                     u_lock_busy,
    input  logic                     u_wr,
    input  logic [2:0]               u_sel,
    input  logic [31:0]              u_wdata,
    input  logic                     u_pop,
    input  logic                     u_force_unlock,
    input  logic                     u_dir_en,
    input  logic                     u_dir_we,
    input  logic [$clog2(DEPTH)-1:0] u_dir_addr,
    input  logic [31:0]              u_dir_wdata,
    output logic                     u_dir_ack,
    output logic [31:0]              u_dir_rdata,
    input  logic                     u_zero_req,
    output logic                     zero_busy,
    input  logic [38:0]              ecc_flip,
    input  logic                     ecc_err_clr,
    output logic                     ecc_err,
    output logic                     ecc_irq,
    output logic [CNTW-1:0]          corr_cnt,
    output logic                     rd_valid,
    output logic [31:0]              rd_data,
    output logic [1:0]               mbx_state,
    output logic                     owner_is_uc,
    output logic [31:0]              mbx_cmd,
    output logic [31:0]              mbx_dlen,
    output logic [1:0]               mbx_status
);

    mbx_state_e  state;
    logic        owner_uc;
    logic        grant, exec_go, din_we;
    logic [31:0] din_data;
    logic        pop, dir_allow, zero_allow;
    logic        rd_single, rd_double;

    mbx_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_lock_rd(h_lock_rd),
        .u_lock_rd(u_lock_rd),
        .u_force  (u_force_unlock),
        .h_wr     (h_wr),
        .h_sel    (h_sel),
        .h_wdata  (h_wdata),
        .u_wr     (u_wr),
        .u_sel    (u_sel),
        .u_wdata  (u_wdata),
        .h_busy   (h_lock_busy),
        .u_busy   (u_lock_busy),
        .state    (state),
        .owner_uc (owner_uc),
        .cmd      (mbx_cmd),
        .dlen     (mbx_dlen),
        .status   (mbx_status),
        .grant    (grant),
        .exec_go  (exec_go),
        .din_we   (din_we),
        .din_data (din_data)
    );

    assign pop        = (state == ST_EXEC_UC && u_pop) || (state == ST_EXEC_HOST && h_pop);
    assign dir_allow  = (state == ST_EXEC_UC);
    assign zero_allow = owner_uc && (state != ST_IDLE);

    mbx_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (grant),
        .exec_go   (exec_go),
        .din_we    (din_we),
        .din_data  (din_data),
        .flip      (ecc_flip),
        .pop       (pop),
        .dlen      (mbx_dlen),
        .dir_en    (u_dir_en),
        .dir_we    (u_dir_we),
        .dir_addr  (u_dir_addr),
        .dir_wdata (u_dir_wdata),
        .dir_allow (dir_allow),
        .zero_req  (u_zero_req),
        .zero_allow(zero_allow),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_single (rd_single),
        .rd_double (rd_double),
        .dir_ack   (u_dir_ack),
        .dir_rdata (u_dir_rdata),
        .zero_busy (zero_busy)
    );

    mbx_err_track #(.CNTW(CNTW)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_valid (rd_valid),
        .rd_single(rd_single),
        .rd_double(rd_double),
        .clr      (ecc_err_clr),
        .err      (ecc_err),
        .irq      (ecc_irq),
        .corr_cnt (corr_cnt)
    );

    assign mbx_state   = state;
    assign owner_is_uc = owner_uc;

    p_dir_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        u_dir_ack |-> $past(state == ST_EXEC_UC));

endmodule

// File: tb/sim_mbx_lock_ctrl.sv
module sim_mbx_lock_ctrl;

    localparam int DEPTH = 8;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          h_lock_rd = 0, h_wr = 0, h_pop = 0;
    logic [2:0]    h_sel = '0;
    logic [31:0]   h_wdata = '0;
    logic          u_lock_rd = 0, u_wr = 0, u_pop = 0, u_force_unlock = 0;
    logic [2:0]    u_sel = '0;
    logic [31:0]   u_wdata = '0;
    logic          u_dir_en = 0, u_dir_we = 0;
    logic [AW-1:0] u_dir_addr = '0;
    logic [31:0]   u_dir_wdata = '0;
    logic          u_zero_req = 0, ecc_err_clr = 0;
    logic [38:0]   ecc_flip = '0;
    logic          h_lock_busy, u_lock_busy, u_dir_ack, zero_busy;
    logic [31:0]   u_dir_rdata, rd_data, mbx_cmd, mbx_dlen;
    logic          ecc_err, ecc_irq, rd_valid, owner_is_uc;
    logic [7:0]    corr_cnt;
    logic [1:0]    mbx_state, mbx_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    mbx_lock_ctrl #(.DEPTH(DEPTH), .CNTW(8)) u0 (
        .clk(clk), .rst_n(rst_n),
        .h_lock_rd(h_lock_rd), .h_lock_busy(h_lock_busy), .h_wr(h_wr), .h_sel(h_sel),
        .h_wdata(h_wdata), .h_pop(h_pop),
        .u_lock_rd(u_lock_rd), .u_lock_busy(u_lock_busy), .u_wr(u_wr), .u_sel(u_sel),
        .u_wdata(u_wdata), .u_pop(u_pop), .u_force_unlock(u_force_unlock),
        .u_dir_en(u_dir_en), .u_dir_we(u_dir_we), .u_dir_addr(u_dir_addr),
        .u_dir_wdata(u_dir_wdata), .u_dir_ack(u_dir_ack), .u_dir_rdata(u_dir_rdata),
        .u_zero_req(u_zero_req), .zero_busy(zero_busy), .ecc_flip(ecc_flip),
        .ecc_err_clr(ecc_err_clr), .ecc_err(ecc_err), .ecc_irq(ecc_irq), .corr_cnt(corr_cnt),
        .rd_valid(rd_valid), .rd_data(rd_data), .mbx_state(mbx_state),
        .owner_is_uc(owner_is_uc), .mbx_cmd(mbx_cmd), .mbx_dlen(mbx_dlen),
        .mbx_status(mbx_status)
    );

    function automatic logic [31:0] pat(input int k, input int i);
        return (32'h1357_9BDF ^ (32'(k) << 16)) + 32'(i) * 32'h0001_0203;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit uc, input logic [2:0] sel, input logic [31:0] v);
        if (uc) begin u_wr = 1; u_sel = sel; u_wdata = v; end
        else    begin h_wr = 1; h_sel = sel; h_wdata = v; end
        tick;
        u_wr = 0; h_wr = 0;
    endtask

    task automatic acquire(input bit uc);
        if (uc) begin u_lock_rd = 1; #1; chk("R1 lock free busy", 32'(u_lock_busy), 0); end
        else    begin h_lock_rd = 1; #1; chk("R1 lock free busy", 32'(h_lock_busy), 0); end
        tick;
        u_lock_rd = 0; h_lock_rd = 0;
        chk("R1 granted state/owner", {30'd0, mbx_state} | (32'(owner_is_uc) << 4), 32'd1 | (32'(uc) << 4));
        chk("R12 status cleared on grant", 32'(mbx_status), 0);
    endtask

    task automatic pop(input bit uc, output logic [31:0] v, output logic ok);
        if (uc) u_pop = 1; else h_pop = 1;
        tick;
        u_pop = 0; h_pop = 0;
        v = rd_data; ok = rd_valid;
    endtask

    task automatic dir(input bit we, input logic [AW-1:0] a, input logic [31:0] v);
        u_dir_en = 1; u_dir_we = we; u_dir_addr = a; u_dir_wdata = v;
        tick;
        u_dir_en = 0; u_dir_we = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        ok;
        int          c;
        repeat (3) tick;
        rst_n = 1;
        tick;

        // reset state
        chk("R1 reset state", 32'(mbx_state), 0);
        chk("R9 reset err", 32'(ecc_err), 0);
        chk("R11 reset zero_busy", 32'(zero_busy), 0);
        chk("R8 reset corr_cnt", 32'(corr_cnt), 0);

        // R2: simultaneous request
        h_lock_rd = 1; u_lock_rd = 1; #1;
        chk("R2 host sees free", 32'(h_lock_busy), 0);
        chk("R2 uc sees busy", 32'(u_lock_busy), 1);
        tick;
        h_lock_rd = 0; u_lock_rd = 0;
        chk("R2 host owns", {30'd0, mbx_state} | (32'(owner_is_uc) << 4), 32'd1);
        u_lock_rd = 1; #1;
        chk("R1 held returns busy", 32'(u_lock_busy), 1);
        tick; u_lock_rd = 0;
        chk("R1 held no change", 32'(owner_is_uc), 0);
        wr(0, 3'd3, 32'd0);
        chk("R4 release from LOCKED", 32'(mbx_state), 0);

        // main sweep
        for (int o = 0; o < 2; o++) begin
            for (int dl = 0; dl <= DEPTH; dl++) begin
                bit uc;
                int k;
                uc = (o == 1);
                k  = o * 16 + dl;
                acquire(uc);
                wr(uc, 3'd0, 32'hC0DE_0000 + 32'(k));
                wr(uc, 3'd1, 32'(dl));
                for (int i = 0; i < DEPTH; i++) wr(uc, 3'd2, pat(k, i));
                chk("R3 cmd stored", mbx_cmd, 32'hC0DE_0000 + 32'(k));
                wr(uc, 3'd3, 32'd1);
                chk("R3 exec state", 32'(mbx_state), uc ? 32'd3 : 32'd2);
                for (int i = 0; i <= DEPTH; i++) begin
                    pop(!uc, v, ok);
                    chk("R7 pop valid", 32'(ok), 1);
                    chk("R7 R13 pop data", v, (i < dl) ? pat(k, i) : 32'd0);
                end
                tick;
                chk("R9 no error clean data", 32'(ecc_err), 0);
                wr(!uc, 3'd4, 32'd1);
                chk("R12 receiver writes DATA_READY", 32'(mbx_status), 1);
                wr(uc, 3'd4, 32'd2);
                chk("R12 owner status write ignored", 32'(mbx_status), 1);
                wr(uc, 3'd3, 32'd0);
                chk("R4 release from exec", 32'(mbx_state), 0);
            end
        end

        // single-bit correction, direct access, rejected zeroize
        acquire(0);
        wr(0, 3'd1, 32'd2);
        ecc_flip = 39'h20;
        wr(0, 3'd2, 32'hAAAA_5555);
        ecc_flip = '0;
        wr(0, 3'd2, 32'h1234_5678);
        dir(0, 3'd1, 32'd0);
        chk("R6 no direct ack in LOCKED", 32'(u_dir_ack), 0);
        wr(0, 3'd3, 32'd1);
        pop(1, v, ok);
        chk("R8 corrected data", v, 32'hAAAA_5555);
        tick;
        chk("R8 corr_cnt incremented", 32'(corr_cnt), 1);
        chk("R8 no err on single", 32'(ecc_err), 0);
        u_zero_req = 1; tick; u_zero_req = 0;
        chk("R11 zeroize rejected under host", 32'(zero_busy), 0);
        dir(0, 3'd1, 32'd0);
        chk("R6 direct ack in UC_EXEC", 32'(u_dir_ack), 1);
        chk("R11 entry kept after rejected zeroize", u_dir_rdata, 32'h1234_5678);
        dir(1, 3'd5, 32'hCAFE_F00D);
        chk("R6 direct write ack", 32'(u_dir_ack), 1);
        dir(0, 3'd5, 32'd0);
        chk("R6 direct readback", u_dir_rdata, 32'hCAFE_F00D);
        wr(0, 3'd3, 32'd0);

        // double fault just past the length
        acquire(1);
        wr(1, 3'd1, 32'd2);
        wr(1, 3'd2, 32'h0000_1111);
        wr(1, 3'd2, 32'h0000_2222);
        ecc_flip = 39'h300;
        wr(1, 3'd2, 32'h0000_3333);
        ecc_flip = '0;
        wr(1, 3'd3, 32'd1);
        chk("R3 uc-owned exec", 32'(mbx_state), 3);
        dir(1, 3'd0, 32'hFFFF_FFFF);
        chk("R6 no direct ack in HOST_EXEC", 32'(u_dir_ack), 0);
        pop(0, v, ok);
        chk("R6 direct write ignored", v, 32'h0000_1111);
        pop(0, v, ok);
        chk("R7 second word", v, 32'h0000_2222);
        pop(0, v, ok);
        chk("R10 past-length pop zero", v, 32'd0);
        tick;
        chk("R10 no err past length", 32'(ecc_err), 0);
        chk("R10 no irq past length", 32'(ecc_irq), 0);
        wr(1, 3'd3, 32'd0);

        // double fault inside the length
        acquire(1);
        wr(1, 3'd1, 32'd1);
        ecc_flip = 39'h300;
        wr(1, 3'd2, 32'h0BAD_0BAD);
        ecc_flip = '0;
        wr(1, 3'd3, 32'd1);
        pop(0, v, ok);
        chk("R9 pop valid", 32'(ok), 1);
        tick;
        chk("R9 err set", 32'(ecc_err), 1);
        chk("R9 irq pulse", 32'(ecc_irq), 1);
        tick;
        chk("R9 irq one cycle", 32'(ecc_irq), 0);
        chk("R9 err sticky", 32'(ecc_err), 1);
        wr(0, 3'd4, 32'd2);
        chk("R12 CMD_FAILURE", 32'(mbx_status), 2);
        u_zero_req = 1; tick; u_zero_req = 0;
        c = 0;
        while (zero_busy && c < 100) begin tick; c++; end
        chk("R11 zeroize span", 32'(c), DEPTH);
        ecc_err_clr = 1; tick; ecc_err_clr = 0;
        chk("R9 err cleared", 32'(ecc_err), 0);
        wr(1, 3'd3, 32'd0);
        acquire(0);
        wr(0, 3'd1, 32'(DEPTH));
        wr(0, 3'd3, 32'd1);
        for (int i = 0; i < DEPTH; i++) begin
            pop(1, v, ok);
            chk("R11 zeroized entry", v, 32'd0);
        end
        tick;
        chk("R11 no err after zeroize", 32'(ecc_err), 0);

        // forced unlock
        u_force_unlock = 1; tick; u_force_unlock = 0;
        chk("R5 forced idle from exec", 32'(mbx_state), 0);
        acquire(0);
        u_force_unlock = 1; tick; u_force_unlock = 0;
        chk("R5 forced idle from LOCKED", 32'(mbx_state), 0);
        acquire(1);
        chk("R5 uc owns after force", 32'(owner_is_uc), 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule